// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Watermarks

This block carries data words from a write clock domain to an unrelated read clock domain. Both the write and read enables are active low. Storage is a simple dual-port array. The write and read pointers are one bit wider than the address, and each crosses to the other domain as Gray code through a chain of synchronizer flops. The write side raises full, almost-full and half-full. The read side raises empty and almost-empty. All five flags are registered, and each updates only on an edge of the clock that owns it.

Two read behaviours are chosen while reset is held. In plain mode a read request moves the next word into the output register on that read edge. In fall-through mode the first stored word moves into the output register with no request. A request then advances to the following word. The output register counts as one more word of capacity in this mode. The almost-full offset m and the almost-empty offset n are taken from parallel pins while reset is low. If the load pin is low, both offsets fall back to DEPTH/8.

A small state machine in the read domain drives the output register. These are its states:
- ST_BOOT: after reset.
- ST_PLAIN: plain mode.
- ST_BARE: fall-through mode, output register empty.
- ST_LOADED: fall-through mode, output register holding a word.

These are its transitions:
- ST_BOOT goes to ST_PLAIN or to ST_BARE, depending on the captured mode.
- ST_BARE goes to ST_LOADED when the memory has a word.
- ST_LOADED stays in ST_LOADED on a pop while the memory still has a word, and reloads the register.
- ST_LOADED goes to ST_BARE on a pop when the memory is empty.
- ST_PLAIN stays in ST_PLAIN until the next reset.

Top module: `fifo_dual_clock`

## Requirements
In the requirements below, T is the number of stored words, output register included. Deff is DEPTH in plain mode and DEPTH+1 in fall-through mode. All flags are active high.

- R1: Words leave the block in the order they were accepted, with every bit unchanged (WIDTH bits, 9 by default).
- R2: `full` is 1 exactly when T equals Deff. A write attempted while `full` is 1 is dropped: the word is never read out and the count does not change.
- R3: `empty` is 1 exactly when T is 0. A read attempted while `empty` is 1 is dropped: `empty` stays 1 and the count does not change.
- R4: In plain mode, `rd_en_n` low on a read edge with `empty` at 0 puts the oldest word on `rd_data` after that edge. While `rd_en_n` is high, `rd_data` holds its value.
- R5: In fall-through mode, the oldest word appears on `rd_data` and `empty` falls with no read request. `rd_en_n` low on a read edge removes that word. While `rd_en_n` is high, `rd_data` holds its value.
- R6: `almost_full` is 1 when T ≥ Deff − m and 0 when T is below that level. It updates on write-clock edges only.
- R7: `almost_empty` is 1 when T ≤ n in plain mode, and when T ≤ n+1 in fall-through mode. It updates on read-clock edges only.
- R8: `half_full` is 1 when T ≥ DEPTH/2+1 in plain mode, and when T ≥ DEPTH/2+2 in fall-through mode.
- R9: On every clock edge while `rst_n` is low, the block samples `fwft_sel` (1 selects fall-through) and the offsets. m comes from `af_off` and n from `ae_off` when `cfg_load` is 1; otherwise both are DEPTH/8. Offsets must be below DEPTH.
- R10: Driving `rst_n` low clears both pointers at once. The flags then read `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `half_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwft_sel | input | 1 | 1 selects fall-through mode, sampled during reset |
| cfg_load | input | 1 | 1 takes offsets from the pins, 0 uses DEPTH/8 |
| af_off | input | $clog2(DEPTH)+1 | Almost-full offset m |
| ae_off | input | $clog2(DEPTH)+1 | Almost-empty offset n |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | WIDTH | Write data |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | WIDTH | Output register |
| full | output | 1 | No room left (write domain) |
| almost_full | output | 1 | Count at or above the high watermark (write domain) |
| half_full | output | 1 | More than half full (write domain) |
| empty | output | 1 | No word readable (read domain) |
| almost_empty | output | 1 | Count at or below the low watermark (read domain) |

## Verification
Each kind of internal fault shows at the ports in its own way:

- A corrupted pointer or memory address shows as a wrong or reordered word on `rd_data` at the very next read.
- A Gray-code or synchronizer fault leaves a flag at the wrong value after the domains have gone quiet. Every flag is compared against the reference count once twelve read cycles have passed with no traffic.
- A wrong state in the output state machine shows within one read cycle: either `rd_data` changes with no request, or `empty` stays high while words are stored.
- An offset or mode captured wrongly moves a flag edge by at least one word. Fill and drain steps of one word each expose this at the first threshold crossed.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;

    // read-side output register states
    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_PLAIN  = 2'd1,
        ST_BARE   = 2'd2,
        ST_LOADED = 2'd3
    } out_state_t;

endpackage

// File: rtl/fifo_gsync.sv
module fifo_gsync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5,
    parameter int DFLT  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          cfg_load,
    input  logic [PW-1:0] af_off,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray_q,
    output logic          full,
    output logic          almost_full,
    output logic          half_full
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2 + 1);
    localparam logic [PW-1:0] DFLT_P  = PW'(DFLT);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] wbin_q, wbin_n, rbin_s, cnt_n, m_q;
    logic          full_q, af_q, hf_q;

    // offset capture while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= cfg_load ? af_off : DFLT_P;
    end

    assign rbin_s = g2b(rgray_s);
    assign we     = !wr_en_n && !full_q;
    assign wbin_n = wbin_q + PW'(we);
    assign cnt_n  = wbin_n - rbin_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            full_q  <= 1'b0;
            af_q    <= 1'b0;
            hf_q    <= 1'b0;
        end else begin
            wbin_q  <= wbin_n;
            wgray_q <= wbin_n ^ (wbin_n >> 1);
            full_q  <= (cnt_n == DEPTH_P);
            af_q    <= (cnt_n >= DEPTH_P - m_q);
            hf_q    <= (cnt_n >= HALF_P);
        end
    end

    assign waddr       = wbin_q[AW-1:0];
    assign full        = full_q;
    assign almost_full = af_q;
    assign half_full   = hf_q;

    assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_q - rbin_s) <= DEPTH_P);
    assert_full_af_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> af_q);
    assert_full_hf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |-> hf_q);
    assert_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_dc_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5,
    parameter int DFLT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_n,
    input  logic             fwft_sel,
    input  logic             cfg_load,
    input  logic [PW-1:0]    ae_off,
    input  logic [PW-1:0]    wgray_s,
    input  logic [WIDTH-1:0] rdata,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray_q,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             almost_empty
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] DFLT_P  = PW'(DFLT);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    out_state_t       state_q, state_n;
    logic [PW-1:0]    rbin_q, rbin_n, wbin_s, cnt_n, n_q;
    logic             mode_q, mem_empty_q, ae_q, load;
    logic [WIDTH-1:0] dout_q;

    // mode and offset capture while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= fwft_sel;
            n_q    <= cfg_load ? ae_off : DFLT_P;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_n;
    end

    // next state and memory load decision
    always_comb begin
        state_n = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_BOOT:   state_n = mode_q ? ST_BARE : ST_PLAIN;
            ST_PLAIN:  load = !rd_en_n && !mem_empty_q;
            ST_BARE: begin
                if (!mem_empty_q) begin
                    load    = 1'b1;
                    state_n = ST_LOADED;
                end
            end
            ST_LOADED: begin
                if (!rd_en_n) begin
                    if (!mem_empty_q) load = 1'b1;
                    else              state_n = ST_BARE;
                end
            end
            default:   state_n = ST_BOOT;
        endcase
    end

    assign wbin_s = g2b(wgray_s);
    assign rbin_n = rbin_q + PW'(load);
    assign cnt_n  = wbin_s - rbin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q      <= '0;
            rgray_q     <= '0;
            mem_empty_q <= 1'b1;
            ae_q        <= 1'b1;
            dout_q      <= '0;
        end else begin
            rbin_q      <= rbin_n;
            rgray_q     <= rbin_n ^ (rbin_n >> 1);
            mem_empty_q <= (cnt_n == '0);
            ae_q        <= (cnt_n <= n_q);
            if (load) dout_q <= rdata;
        end
    end

    assign raddr        = rbin_q[AW-1:0];
    assign rd_data      = dout_q;
    assign empty        = (state_q == ST_PLAIN) ? mem_empty_q : (state_q != ST_LOADED);
    assign almost_empty = ae_q;

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wbin_s - rbin_q) <= DEPTH_P);
    assert_plain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAIN && rd_en_n) |=> $stable(dout_q));
    assert_fall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOADED && rd_en_n) |=> ($stable(dout_q) && state_q == ST_LOADED));
    assert_empty_ae_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLAIN && mem_empty_q) |-> ae_q);
endmodule

// File: rtl/fifo_dual_clock.sv
module fifo_dual_clock #(
    parameter int WIDTH       = 9,
    parameter int DEPTH       = 16,
    parameter int DFLT_OFF    = DEPTH / 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   wr_clk,
    input  logic                   rd_clk,
    input  logic                   rst_n,
    input  logic                   fwft_sel,
    input  logic                   cfg_load,
    input  logic [$clog2(DEPTH):0] af_off,
    input  logic [$clog2(DEPTH):0] ae_off,
    input  logic                   wr_en_n,
    input  logic [WIDTH-1:0]       wr_data,
    input  logic                   rd_en_n,
    output logic [WIDTH-1:0]       rd_data,
    output logic                   full,
    output logic                   almost_full,
    output logic                   half_full,
    output logic                   empty,
    output logic                   almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             we;
    logic [AW-1:0]    waddr, raddr;
    logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
    logic [WIDTH-1:0] rdata;

    fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rdata)
    );

    fifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    fifo_gsync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .DFLT(DFLT_OFF)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .cfg_load(cfg_load),
        .af_off(af_off), .rgray_s(rgray_s), .we(we), .waddr(waddr),
        .wgray_q(wgray), .full(full), .almost_full(almost_full),
        .half_full(half_full)
    );

    fifo_rd_ctl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .PW(PW), .DFLT(DFLT_OFF)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .fwft_sel(fwft_sel),
        .cfg_load(cfg_load), .ae_off(ae_off), .wgray_s(wgray_s), .rdata(rdata),
        .raddr(raddr), .rgray_q(rgray), .rd_data(rd_data), .empty(empty),
        .almost_empty(almost_empty)
    );
endmodule

// File: tb/sim_fifo_dual_clock.sv
module sim_fifo_dual_clock;
    localparam int WCLK_P = 10;
    localparam int RCLK_P = 14;
    localparam int D      = 16;
    localparam int W      = 9;
    localparam int PW     = $clog2(D) + 1;

    logic          wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic          fwft_sel = 0, cfg_load = 0;
    logic [PW-1:0] af_off = '0, ae_off = '0;
    logic          wr_en_n = 1, rd_en_n = 1;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          full, almost_full, half_full, empty, almost_empty;

    int checks = 0, bad = 0;
    logic [W-1:0] q[$];
    int m_e, n_e;
    bit fw;

    always #(WCLK_P / 2) wr_clk = ~wr_clk;
    always #(RCLK_P / 2) rd_clk = ~rd_clk;

    fifo_dual_clock #(.WIDTH(W), .DEPTH(D)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .cfg_load(cfg_load), .af_off(af_off), .ae_off(ae_off),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .rd_data(rd_data), .full(full), .almost_full(almost_full),
        .half_full(half_full), .empty(empty), .almost_empty(almost_empty)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (count=%0d fwft=%0d)", tag, act, exp, q.size(), fw);
        end
    endtask

    function automatic int cap();
        return fw ? D + 1 : D;
    endfunction
    function automatic int e_full(int t);  return int'(t == cap()); endfunction
    function automatic int e_af(int t);    return int'(t >= cap() - m_e); endfunction
    function automatic int e_hf(int t);    return int'(t >= (fw ? D / 2 + 2 : D / 2 + 1)); endfunction
    function automatic int e_ae(int t);    return int'(t <= (fw ? n_e + 1 : n_e)); endfunction
    function automatic int e_empty(int t); return int'(t == 0); endfunction

    task automatic settle_check();
        int t;
        repeat (12) @(negedge rd_clk);
        t = q.size();
        chk("R2 full", int'(full), e_full(t));
        chk("R6 R9 almost_full", int'(almost_full), e_af(t));
        chk("R8 half_full", int'(half_full), e_hf(t));
        chk("R7 R9 almost_empty", int'(almost_empty), e_ae(t));
        chk("R3 empty", int'(empty), e_empty(t));
    endtask

    task automatic wr_loop(int iters, int pct);
        bit pend = 0;
        logic [W-1:0] v = '0;
        for (int i = 0; i < iters; i++) begin
            @(negedge wr_clk);
            if (pend) q.push_back(v);
            pend = 0;
            if (($urandom % 100) < pct) begin
                wr_en_n = 0;
                wr_data = W'($urandom % (1 << W));
                v = wr_data;
                pend = !full;
            end else begin
                wr_en_n = 1;
            end
        end
        @(negedge wr_clk);
        if (pend) q.push_back(v);
        wr_en_n = 1;
    endtask

    task automatic rd_loop(int iters, int pct);
        bit pend = 0;
        logic [W-1:0] e = '0;
        for (int i = 0; i < iters; i++) begin
            @(negedge rd_clk);
            if (pend) chk("R1 R4 plain data", int'(rd_data), int'(e));
            pend = 0;
            if (fw && !empty && q.size() > 0)
                chk("R1 R5 fall-through data", int'(rd_data), int'(q[0]));
            rd_en_n = !((($urandom % 100) < pct));
            if (!rd_en_n && !empty && q.size() > 0) begin
                if (fw) void'(q.pop_front());
                else begin
                    e = q.pop_front();
                    pend = 1;
                end
            end
        end
        @(negedge rd_clk);
        if (pend) chk("R1 R4 plain data", int'(rd_data), int'(e));
        rd_en_n = 1;
    endtask

    task automatic run_cfg(bit f, bit ld, int m, int n);
        logic [W-1:0] held;
        fw = f;
        m_e = ld ? m : D / 8;
        n_e = ld ? n : D / 8;
        q.delete();
        rst_n = 0;
        fwft_sel = f;
        cfg_load = ld;
        af_off = PW'(m);
        ae_off = PW'(n);
        repeat (4) @(negedge rd_clk);
        rst_n = 1;
        // R10 reset state
        @(negedge wr_clk);
        chk("R10 empty", int'(empty), 1);
        chk("R10 almost_empty", int'(almost_empty), 1);
        chk("R10 full", int'(full), 0);
        chk("R10 almost_full", int'(almost_full), 0);
        chk("R10 half_full", int'(half_full), 0);
        // R3 read while empty is dropped
        held = rd_data;
        rd_loop(3, 100);
        chk("R3 R4 rd_data held while empty", int'(rd_data), int'(held));
        settle_check();
        // fill one word at a time
        for (int k = 0; k < cap(); k++) begin
            wr_loop(1, 100);
            settle_check();
            if (fw && k == 0) chk("R5 first word shown unrequested", int'(rd_data), int'(q[0]));
        end
        // R2 write while full is dropped
        wr_loop(2, 100);
        settle_check();
        chk("R2 count after overfill", q.size(), cap());
        // drain one word at a time
        while (q.size() > 0) begin
            rd_loop(1, 100);
            settle_check();
        end
        // random traffic, heavy write then heavy read
        wr_loop(40, 90);
        fork
            wr_loop(400, 70);
            rd_loop(300, 30);
        join
        settle_check();
        fork
            wr_loop(300, 30);
            rd_loop(400, 80);
        join
        settle_check();
        for (int g = 0; g < 20 && q.size() > 0; g++) rd_loop(4, 100);
        settle_check();
    endtask

    initial begin
        #(WCLK_P * 150000);
        checks++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        run_cfg(0, 1, 3, 2);
        run_cfg(1, 1, 5, 4);
        run_cfg(0, 0, 0, 0);
        run_cfg(1, 0, 0, 0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule